// File: doc/BRIEF.md
# Serial Character Receiver with Per-Entry Error Tags

This block is the receive half of a classic asynchronous serial port. It watches a single serial input, oversampled by an external enable pulse that arrives sixteen times per bit period. It checks each start bit at mid-bit and shifts in 5 to 8 data bits, least significant first. It then samples an optional parity bit and the first stop bit. Each finished character is kept together with three flags of its own: a parity mismatch, a bad stop bit and a line break.

Finished characters go into a receive buffer. With buffering switched off, the buffer holds a single character. With buffering switched on, it holds up to sixteen characters in arrival order. A one-cycle read strobe pops the oldest entry, and the character and its flags are visible on the outputs before the pop. A character that arrives when no space is left is dropped, and a sticky overrun flag records the loss until a status-read strobe clears it.

A data-available interrupt is produced from the buffer state. When buffering is off, the interrupt follows the occupancy of the single holding slot. When buffering is on, it compares the fill level against a selectable threshold.

Top module: `uart_rx_tagged`

## Requirements
- R1: After reset the buffer is empty (`rx_count` = 0), `irq` is 0 and `overrun` is 0.
- R2: A low on `rx` is taken as a start bit only if the line is still low 8 sample ticks after the low was first seen. A shorter low pulse stores nothing.
- R3: `word_len` selects the data bits: 0 = 5, 1 = 6, 2 = 7, 3 = 8. Bits arrive LSB first. The stored character is right-justified, and its unused upper bits are zero.
- R4: `parity_mode` selects the parity: 0 or 3 = no parity bit, 1 = even, 2 = odd. When the received parity bit does not match the parity of the data bits, the entry's `rx_pe` is 1; otherwise it is 0.
- R5: If the first stop bit is sampled low, the entry's `rx_fe` is 1. Only the first stop bit is checked.
- R6: If the line stays low from the start bit through the stop bit, exactly one entry is stored: character 0 with `rx_brk` = 1 and `rx_fe` = 1. No further entry is stored until the line has gone high again.
- R7: The buffer capacity is 1 entry when `fifo_on` = 0 and 16 entries when `fifo_on` = 1. `rx_count` never exceeds this capacity. `fifo_on` may change only while the buffer is empty.
- R8: While `rx_count` > 0, the outputs `rx_char`, `rx_pe`, `rx_fe` and `rx_brk` show the oldest entry. A one-cycle `rd_data` pulse removes that entry. A pulse on an empty buffer has no effect.
- R9: A character that completes while the buffer is at capacity is discarded, and `overrun` becomes 1 and stays 1. A `rd_status` pulse clears it.
- R10: When `fifo_on` = 0 and `irq_en` = 1, `irq` is 1 exactly while the holding slot is occupied. It therefore falls when that character is read.
- R11: When `fifo_on` = 1 and `irq_en` = 1, `irq` is 1 exactly while `rx_count` is at or above the threshold set by `trig_sel`: 0 = 1, 1 = 4, 2 = 8, 3 = 14.
- R12: When `irq_en` = 0, `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx | input | 1 | Serial input line, idles high |
| word_len | input | 2 | Data-bit count select |
| parity_mode | input | 2 | Parity select |
| fifo_on | input | 1 | 1 = 16-entry buffer, 0 = single holding slot |
| trig_sel | input | 2 | Interrupt threshold select used when buffering is on |
| irq_en | input | 1 | Data-available interrupt enable |
| rd_data | input | 1 | Pop strobe for the oldest entry |
| rd_status | input | 1 | Status-read strobe that clears the overrun flag |
| rx_char | output | 8 | Character of the oldest entry |
| rx_pe | output | 1 | Parity-error flag of the oldest entry |
| rx_fe | output | 1 | Framing-error flag of the oldest entry |
| rx_brk | output | 1 | Break flag of the oldest entry |
| rx_count | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky lost-character flag |
| irq | output | 1 | Data-available interrupt |

## Verification
The assertions check several rules on every cycle. The fill level never exceeds the mode's capacity, and a rejected character always sets the overrun flag. A pop on an empty buffer leaves it empty, and a break entry always carries a zero character. The interrupt rises on the push that reaches the threshold or fills the holding slot, falls when that slot is read, and stays low while disabled. Other behaviour can be shown only by the bench's serial frames: glitch rejection, bit order and justification for each word length, correct detection of good and bad parity, a break stored once per low period, and the order in which entries come out of the buffer.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } rx_entry_t;

  // index of the last data bit: 4..7
  function automatic logic [2:0] last_bit(input logic [1:0] wl);
    return {1'b0, wl} + 3'd4;
  endfunction

  // shifted-in bits sit at the top of the register; move them down
  function automatic logic [7:0] justify(input logic [7:0] sh, input logic [1:0] wl);
    return sh >> (2'd3 - wl);
  endfunction

  function automatic logic xor_all(input logic [7:0] d);
    return ^d;
  endfunction

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
  import urx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx,
  input  logic [1:0] word_len,
  input  logic [1:0] parity_mode,
  output logic      done,
  output rx_entry_t ent
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_t;

  st_t        st;
  logic [3:0] cnt;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       pbit, seen_high;
  logic       rx_m, rx_s;

  logic mid, par_en, par_odd;
  logic start_ok, start_glitch, frame_done;
  rx_entry_t frame_ent;

  assign mid      = (cnt == 4'hF);
  assign par_en   = (parity_mode == 2'd1) || (parity_mode == 2'd2);
  assign par_odd  = (parity_mode == 2'd2);
  assign start_ok     = tick && (st == S_START) && (cnt == 4'd7) && !rx_s;
  assign start_glitch = tick && (st == S_START) && (cnt == 4'd7) && rx_s;
  assign frame_done   = tick && (st == S_STOP) && mid;

  always_comb begin
    frame_ent.data = justify(sh, word_len);
    frame_ent.pe   = par_en && (pbit != (xor_all(frame_ent.data) ^ par_odd));
    frame_ent.fe   = !rx_s;
    frame_ent.brk  = !seen_high && !rx_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; sh <= '0;
      pbit <= 1'b0; seen_high <= 1'b0; done <= 1'b0; ent <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin st <= S_START; cnt <= '0; end
          S_START: begin
            if (start_ok) begin
              st <= S_DATA; cnt <= '0; bidx <= '0; seen_high <= 1'b0;
            end else if (start_glitch) st <= S_IDLE;
            else cnt <= cnt + 4'd1;
          end
          S_DATA: begin
            cnt <= cnt + 4'd1;
            if (mid) begin
              sh <= {rx_s, sh[7:1]};
              seen_high <= seen_high | rx_s;
              if (bidx == last_bit(word_len)) st <= par_en ? S_PAR : S_STOP;
              else bidx <= bidx + 3'd1;
            end
          end
          S_PAR: begin
            cnt <= cnt + 4'd1;
            if (mid) begin
              pbit <= rx_s; seen_high <= seen_high | rx_s; st <= S_STOP;
            end
          end
          S_STOP: begin
            cnt <= cnt + 4'd1;
            if (frame_done) begin
              done <= 1'b1; ent <= frame_ent;
              st <= rx_s ? S_IDLE : S_HOLD;
            end
          end
          S_HOLD:  if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R5
  stop_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == S_STOP));
  // R6
  brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ent.brk) |-> (ent.data == 8'd0 && ent.fe));
  // R2
  glitch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_glitch |=> !done);

endmodule

// File: rtl/urx_buffer.sv
module urx_buffer
  import urx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_on,
  input  logic          push,
  input  rx_entry_t     wdata,
  input  logic          pop,
  input  logic          status_rd,
  output rx_entry_t     head,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          overrun
);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          pop_ok, push_drop;

  assign cap       = fifo_on ? CW'(DEPTH) : CW'(1);
  assign push_ok   = push && (count < cap);
  assign push_drop = push && !(count < cap);
  assign pop_ok    = pop && (count != '0);
  assign head      = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; overrun <= 1'b0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (push_drop)      overrun <= 1'b1;
      else if (status_rd) overrun <= 1'b0;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> overrun);
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !push) |=> count == '0);

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import urx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          rx,
  input  logic [1:0]    word_len,
  input  logic [1:0]    parity_mode,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  input  logic          rd_data,
  input  logic          rd_status,
  output logic [7:0]    rx_char,
  output logic          rx_pe,
  output logic          rx_fe,
  output logic          rx_brk,
  output logic [CW-1:0] rx_count,
  output logic          overrun,
  output logic          irq
);

  logic          char_done, push_ok;
  rx_entry_t     new_ent, head;
  logic [CW-1:0] thr;
  logic          irq_cond;

  urx_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx),
    .word_len(word_len), .parity_mode(parity_mode),
    .done(char_done), .ent(new_ent)
  );

  urx_buffer #(.DEPTH(DEPTH)) u_buffer (
    .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on),
    .push(char_done), .wdata(new_ent), .pop(rd_data), .status_rd(rd_status),
    .head(head), .count(rx_count), .push_ok(push_ok), .overrun(overrun)
  );

  assign thr      = CW'(trig_level(trig_sel));
  assign irq_cond = fifo_on ? (rx_count >= thr) : (rx_count != '0);
  assign irq      = irq_en && irq_cond;

  assign rx_char = head.data;
  assign rx_pe   = head.pe;
  assign rx_fe   = head.fe;
  assign rx_brk  = head.brk;

  // R10
  hold_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && irq_en && push_ok) |=> irq);
  // R10
  hold_irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && rd_data && rx_count == CW'(1) && !char_done) |=> !irq);
  // R11
  trig_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on && irq_en && $stable(trig_sel) && push_ok && !rd_data
     && rx_count == thr - CW'(1)) |=> irq);
  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

// File: tb/tb_uart_rx_tagged.sv
module tb_uart_rx_tagged;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sample_tick = 1'b0, rx = 1'b1;
  logic [1:0] word_len = 2'd3, parity_mode = 2'd0, trig_sel = 2'd0;
  logic       fifo_on = 1'b0, irq_en = 1'b1, rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] rx_char;
  logic       rx_pe, rx_fe, rx_brk, overrun, irq;
  logic [4:0] rx_count;
  logic [1:0] div = 2'd0;

  int n_cmp = 0, n_bad = 0;
  bit auto_drain = 1'b0;
  logic [10:0] exp_q[$];
  string       tag_q[$];

  uart_rx_tagged dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx(rx),
    .word_len(word_len), .parity_mode(parity_mode), .fifo_on(fifo_on),
    .trig_sel(trig_sel), .irq_en(irq_en), .rd_data(rd_data), .rd_status(rd_status),
    .rx_char(rx_char), .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_brk(rx_brk),
    .rx_count(rx_count), .overrun(overrun), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    div <= div + 2'd1;
    sample_tick <= (div == 2'd3);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic compare_head();
    logic [10:0] act;
    act = {rx_brk, rx_fe, rx_pe, rx_char};
    if (exp_q.size() == 0) chk(1'b0, "R8 unexpected entry", {21'd0, act}, 32'd0);
    else begin
      logic [10:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(act == e, t, {21'd0, act}, {21'd0, e});
    end
  endtask

  task automatic pop_one();
    compare_head();
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
    @(negedge clk);
  endtask

  // monitor: drains entries and compares them against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (auto_drain && rx_count != 0) begin
        compare_head();
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
      end
    end
  end

  task automatic bit_time();
    repeat (64) @(negedge clk);
  endtask

  // driver: queue the expected entry, then serialise the frame
  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                      input bit expect_it, input string tag);
    int n;
    logic [7:0] m;
    logic p;
    n = 5 + int'(word_len);
    m = 8'hFF >> (8 - n);
    if (expect_it) begin
      exp_q.push_back({1'b0, bad_stop,
                       bad_par && (parity_mode == 2'd1 || parity_mode == 2'd2), d & m});
      tag_q.push_back(tag);
    end
    rx = 1'b0; bit_time();
    for (int i = 0; i < n; i++) begin rx = d[i]; bit_time(); end
    if (parity_mode == 2'd1 || parity_mode == 2'd2) begin
      p = (^(d & m)) ^ (parity_mode == 2'd2) ^ bad_par;
      rx = p; bit_time();
    end
    rx = !bad_stop; bit_time();
    rx = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic wait_empty(input string tag);
    for (int i = 0; i < 400 && (exp_q.size() != 0 || rx_count != 0); i++) @(negedge clk);
    chk(exp_q.size() == 0 && rx_count == 0, tag, {27'd0, rx_count}, 32'd0);
  endtask

  initial begin
    #4000000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(rx_count == 0, "R1 count", {27'd0, rx_count}, 0);
    chk(irq == 0, "R1 irq", {31'd0, irq}, 0);
    chk(overrun == 0, "R1 overrun", {31'd0, overrun}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R3 R10 single holding slot, 8N1
    send(8'hA5, 0, 0, 1, "R3 8-bit char");
    chk(irq == 1, "R10 irq on arrival", {31'd0, irq}, 1);
    chk(rx_count == 1, "R7 holding count", {27'd0, rx_count}, 1);
    pop_one();
    chk(irq == 0, "R10 irq after read", {31'd0, irq}, 0);

    auto_drain = 1'b1;
    // R3 5-bit word, upper bits zero
    word_len = 2'd0;
    send(8'hF5, 0, 0, 1, "R3 5-bit char");
    word_len = 2'd3;
    wait_empty("R3 drained");

    // R4 parity modes
    parity_mode = 2'd1;
    send(8'h3C, 0, 0, 1, "R4 even good");
    send(8'h3D, 1, 0, 1, "R4 even bad");
    parity_mode = 2'd2;
    send(8'h81, 0, 0, 1, "R4 odd good");
    send(8'h07, 1, 0, 1, "R4 odd bad");
    parity_mode = 2'd0;
    wait_empty("R4 drained");

    // R5 framing error
    send(8'h5A, 0, 1, 1, "R5 framing flag");
    wait_empty("R5 drained");

    // R6 break: line low for a whole frame and more
    exp_q.push_back(11'b110_0000_0000);
    tag_q.push_back("R6 break entry");
    rx = 1'b0;
    repeat (3 * 640) @(negedge clk);
    rx = 1'b1;
    repeat (128) @(negedge clk);
    wait_empty("R6 single break entry");

    // R2 short low pulse
    rx = 1'b0; repeat (12) @(negedge clk); rx = 1'b1;
    repeat (300) @(negedge clk);
    chk(rx_count == 0, "R2 glitch ignored", {27'd0, rx_count}, 0);
    chk(exp_q.size() == 0, "R2 no entry", exp_q.size(), 0);

    // R9 R7 overrun in holding mode
    auto_drain = 1'b0;
    send(8'h11, 0, 0, 1, "R8 kept char");
    send(8'h22, 0, 0, 0, "");
    chk(overrun == 1, "R9 holding overrun", {31'd0, overrun}, 1);
    chk(rx_count == 1, "R7 holding capacity", {27'd0, rx_count}, 1);
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
    chk(overrun == 0, "R9 cleared by status read", {31'd0, overrun}, 0);
    pop_one();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    chk(rx_count == 0, "R8 pop on empty", {27'd0, rx_count}, 0);

    // R11 threshold 4
    fifo_on = 1'b1; trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) send(8'h40 + 8'(i), 0, 0, 1, "R8 order");
    chk(irq == 0, "R11 below level 4", {31'd0, irq}, 0);
    send(8'h43, 0, 0, 1, "R8 order");
    chk(irq == 1, "R11 at level 4", {31'd0, irq}, 1);
    pop_one();
    chk(irq == 0, "R11 back below 4", {31'd0, irq}, 0);
    for (int i = 0; i < 3; i++) pop_one();

    // R7 R9 R11 R12 full buffer
    trig_sel = 2'd3;
    for (int i = 0; i < 16; i++) send(8'h80 + 8'(i), 0, 0, 1, "R8 full order");
    chk(rx_count == 16, "R7 fifo capacity", {27'd0, rx_count}, 16);
    send(8'hEE, 0, 0, 0, "");
    chk(overrun == 1, "R9 fifo overrun", {31'd0, overrun}, 1);
    chk(rx_count == 16, "R9 dropped char", {27'd0, rx_count}, 16);
    irq_en = 1'b0; @(negedge clk);
    chk(irq == 0, "R12 disabled", {31'd0, irq}, 0);
    irq_en = 1'b1; @(negedge clk);
    chk(irq == 1, "R11 full above 14", {31'd0, irq}, 1);
    pop_one(); pop_one();
    chk(irq == 1, "R11 at level 14", {31'd0, irq}, 1);
    pop_one();
    chk(irq == 0, "R11 below level 14", {31'd0, irq}, 0);
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
    auto_drain = 1'b1;
    wait_empty("R8 fifo drained");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule